// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register Block

This block keeps the programmable state of an interrupt router. Software sees only two locations in the block's aperture: a selector at offset 0x00 and a data window at offset 0x10. The selector value decides which internal word a window access reaches. That word can be the device identifier, a read-only version word, or one 32-bit half of a 64-bit redirection entry. There is one redirection entry for each interrupt pin.

The whole table goes out on a flat bus to the delivery logic. The block also produces two single-cycle strobes. The first reports that an entry's mask bit changed. The second asks for service of a level-triggered pin that is still pending after its entry was rewritten. The block also samples the raw pin levels. It applies each entry's polarity to get a pending bit per pin. When the delivery logic accepts a level-triggered interrupt, the block sets that entry's remote-pending bit.

Top module: `ioredir_regs`

## Requirements
- R1: After reset every entry holds mask = 1 and all other bits 0, so the low half reads 0x00010000 and the high half reads 0. The selector, the identifier and all pending bits are 0.
- R2: A window read with selector 0x01 returns (NPINS−1) in bits [23:16] and VER_CODE in bits [7:0], with all other bits 0. The default value is 0x00170011. Window writes at this selector change nothing.
- R3: A window write with selector 0x00 loads the 4-bit identifier from data bits [27:24]. Window reads at selectors 0x00 and 0x02 both return the identifier in bits [27:24] and 0 elsewhere. Window writes at selector 0x02 are ignored.
- R4: For selectors 0x10 and above, the entry index is (selector − 0x10) >> 1. An odd selector reaches bits [63:32] of the entry and an even selector reaches bits [31:0]. The field positions are:
  - vector [7:0]
  - delivery mode [10:8]
  - destination mode [11]
  - polarity [13]
  - remote-pending [14]
  - trigger [15] (1 = level)
  - mask [16]
  - destination [63:56]
- R5: A window write whose index is NPINS or more leaves the table unchanged, and a window read there returns 0. Selectors 0x03 to 0x0F also read 0 and accept no write.
- R6: A write takes effect only when bus_bytes is 4 or 8, and only bus_wdata[31:0] is used. Any other size leaves the selector, the identifier and the table unchanged.
- R7: A write to the low half of an entry always leaves remote-pending at 0, whatever data bit 14 is.
- R8: A pulse on acc_valid sets remote-pending of entry acc_pin when that entry is level-triggered, and does nothing for edge-triggered entries. A write to the high half leaves remote-pending unchanged.
- R9: A low-half write that changes the mask bit raises mask_evt for one cycle, in the cycle after the write. The pulse carries the pin in mask_evt_pin and the new mask in mask_evt_val. A write that keeps the mask raises nothing.
- R10: Any table write raises svc_req for one cycle, in the cycle after the write, with svc_pin set to the index, when all of the following hold:
  - the entry after the write is level-triggered
  - the entry after the write is unmasked
  - the pin's pending bit is set at the time of the write
- R11: Only the low 8 address bits are decoded. A read at any offset other than 0x00 or 0x10 returns 0, and a write there changes nothing. The selector keeps data bits [7:0] and reads back zero-extended.
- R12: tbl_flat[64·i +: 64] always equals entry i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Offset within the aperture |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_bytes | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered and held until the next read |
| pin_in | input | NPINS | Raw interrupt pin levels |
| acc_valid | input | 1 | Delivery logic accepted an interrupt |
| acc_pin | input | IDX_W | Pin of the accepted interrupt |
| tbl_flat | output | 64·NPINS | All redirection entries |
| mask_evt | output | 1 | Mask-change strobe |
| mask_evt_pin | output | IDX_W | Pin whose mask changed |
| mask_evt_val | output | 1 | New mask value |
| svc_req | output | 1 | Service request strobe |
| svc_pin | output | IDX_W | Pin to service |

## Verification
Writes, the acc_valid pulse and read data all take effect at the clock edge that samples the strobe. mask_evt, svc_req, bus_rdata and tbl_flat can therefore be observed one time unit after that edge, and that is where the bench samples them before lowering the strobe. Pending bits take one more edge to follow pin_in. The bench therefore waits two cycles after moving a pin before the write that should raise a service request. It also checks the case where a polarity change and the write land on the same edge, so the old pending value is the one that counts.

// File: rtl/ioredir_pkg.sv
// Package: shared field positions, offsets, selector codes and the
// window-target type for the redirection register block.
package ioredir_pkg;
    localparam int ENT_W  = 64;
    localparam int HALF_W = 32;

    // Bit positions inside one redirection entry.
    localparam int F_VEC    = 0;
    localparam int F_DLV    = 8;
    localparam int F_DSTM   = 11;
    localparam int F_POL    = 13;
    localparam int F_RPEND  = 14;
    localparam int F_TRIG   = 15;
    localparam int F_MASK   = 16;
    localparam int F_DEST   = 56;

    // Aperture offsets (low 8 address bits).
    localparam logic [7:0] OFS_SEL = 8'h00;
    localparam logic [7:0] OFS_WIN = 8'h10;

    // Selector codes.
    localparam logic [7:0] SEL_ID   = 8'h00;
    localparam logic [7:0] SEL_VER  = 8'h01;
    localparam logic [7:0] SEL_ARB  = 8'h02;
    localparam logic [7:0] SEL_TBL  = 8'h10;

    typedef enum logic [2:0] {
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_TBL,
        TGT_NONE
    } tgt_e;

    // Only 4- and 8-byte accesses are accepted.
    function automatic logic size_ok(input logic [3:0] nbytes);
        return (nbytes == 4'd4) || (nbytes == 4'd8);
    endfunction
endpackage

// File: rtl/ioredir_decode.sv
// Module: ioredir_decode
// Maps the selector value to a window target, an entry index and a
// half flag. Assumes an 8-bit selector; indices at or past NPINS
// decode to TGT_NONE so that no entry is touched.
module ioredir_decode #(
    parameter int NPINS = 24,
    parameter int IDX_W = $clog2(NPINS)
) (
    input  logic [7:0]        sel,
    output ioredir_pkg::tgt_e tgt,
    output logic [IDX_W-1:0]  idx,
    output logic              hi
);
    import ioredir_pkg::*;

    logic [7:0] full_idx;

    // Purpose: compute the entry index and classify the selector.
    always_comb begin
        full_idx = (sel - SEL_TBL) >> 1;
        idx      = IDX_W'(full_idx);
        hi       = sel[0];
        if (sel == SEL_ID)
            tgt = TGT_ID;
        else if (sel == SEL_VER)
            tgt = TGT_VER;
        else if (sel == SEL_ARB)
            tgt = TGT_ARB;
        else if ((sel >= SEL_TBL) && (int'(full_idx) < NPINS))
            tgt = TGT_TBL;
        else
            tgt = TGT_NONE;
    end
endmodule

// File: rtl/ioredir_entry.sv
// Module: ioredir_entry
// One 64-bit redirection entry. It resets masked. A low-half write
// always clears remote-pending, and the set input raises remote-pending
// unless a low-half write happens in the same cycle.
module ioredir_entry (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        set_rpend,
    output logic [63:0] bits
);
    import ioredir_pkg::*;

    // Purpose: hold the entry and apply half writes and remote-pending set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= 64'(1) << F_MASK;
        end else begin
            if (wr_hi)
                bits[63:32] <= wdata;
            if (wr_lo) begin
                bits[31:0]    <= wdata;
                bits[F_RPEND] <= 1'b0;
            end else if (set_rpend) begin
                bits[F_RPEND] <= 1'b1;
            end
        end
    end

    // R7: a low-half write leaves remote-pending clear.
    assert_lo_clears_rpend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !bits[F_RPEND]);

    // R8: an accepted level interrupt sets remote-pending.
    assert_set_rpend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_rpend && !wr_lo) |=> bits[F_RPEND]);
endmodule

// File: rtl/ioredir_rdmux.sv
// Module: ioredir_rdmux
// Combinational read-data selection for the aperture. It returns the
// selector, the identifier, the version word or one entry half, and 0
// for anything else. Assumes idx is in range whenever tgt is TGT_TBL.
module ioredir_rdmux #(
    parameter int         NPINS    = 24,
    parameter int         IDX_W    = $clog2(NPINS),
    parameter logic [7:0] VER_CODE = 8'h11
) (
    input  logic [7:0]        ofs,
    input  logic [7:0]        sel,
    input  ioredir_pkg::tgt_e tgt,
    input  logic [IDX_W-1:0]  idx,
    input  logic              hi,
    input  logic [3:0]        dev_id,
    input  logic [63:0]       ents [NPINS],
    output logic [31:0]       word
);
    import ioredir_pkg::*;

    localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

    logic [63:0] ent_sel;

    // Purpose: pick the addressed entry without indexing past the table.
    always_comb begin
        ent_sel = '0;
        for (int i = 0; i < NPINS; i++)
            if (idx == IDX_W'(i))
                ent_sel = ents[i];
    end

    // Purpose: build the read word from the offset and window target.
    always_comb begin
        word = '0;
        if (ofs == OFS_SEL) begin
            word = {24'h0, sel};
        end else if (ofs == OFS_WIN) begin
            case (tgt)
                TGT_ID, TGT_ARB: word = {4'h0, dev_id, 24'h0};
                TGT_VER:         word = {8'h00, MAX_PIN, 8'h00, VER_CODE};
                TGT_TBL:         word = hi ? ent_sel[63:32] : ent_sel[31:0];
                default:         word = '0;
            endcase
        end
    end
endmodule

// File: rtl/ioredir_regs.sv
// Module: ioredir_regs (top)
// Register block reached through a selector/window pair. It holds the
// identifier, the redirection table and the per-pin pending bits, and it
// raises mask-change and service strobes one cycle after a window write.
// Assumes one bus operation per cycle and that decode outside the
// aperture is done elsewhere.
module ioredir_regs #(
    parameter int         NPINS    = 24,
    parameter int         IDX_W    = $clog2(NPINS),
    parameter logic [7:0] VER_CODE = 8'h11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [3:0]            bus_bytes,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NPINS-1:0]      pin_in,
    input  logic                  acc_valid,
    input  logic [IDX_W-1:0]      acc_pin,
    output logic [64*NPINS-1:0]   tbl_flat,
    output logic                  mask_evt,
    output logic [IDX_W-1:0]      mask_evt_pin,
    output logic                  mask_evt_val,
    output logic                  svc_req,
    output logic [IDX_W-1:0]      svc_pin
);
    import ioredir_pkg::*;

    logic [7:0]       sel_q;
    logic [3:0]       id_q;
    logic [NPINS-1:0] irr_q;
    tgt_e             tgt;
    logic [IDX_W-1:0] idx;
    logic             hi;
    logic             wr_ok, win_wr, tbl_wr;
    logic [63:0]      ent_q [NPINS];
    logic [NPINS-1:0] mask_v, pol_v, trig_v;
    logic [63:0]      cur;
    logic             cur_irr;
    logic             new_trig, new_mask;
    logic [31:0]      rd_word;

    ioredir_decode #(.NPINS(NPINS), .IDX_W(IDX_W)) u_dec (
        .sel (sel_q),
        .tgt (tgt),
        .idx (idx),
        .hi  (hi)
    );

    assign wr_ok  = bus_wr && size_ok(bus_bytes);
    assign win_wr = wr_ok && (bus_addr == OFS_WIN);
    assign tbl_wr = win_wr && (tgt == TGT_TBL);

    for (genvar i = 0; i < NPINS; i++) begin : g_ent
        logic wr_lo_i, wr_hi_i, set_rp_i;
        assign wr_lo_i  = tbl_wr && !hi && (idx == IDX_W'(i));
        assign wr_hi_i  = tbl_wr &&  hi && (idx == IDX_W'(i));
        assign set_rp_i = acc_valid && (acc_pin == IDX_W'(i)) && ent_q[i][F_TRIG];

        ioredir_entry u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (wr_lo_i),
            .wr_hi     (wr_hi_i),
            .wdata     (bus_wdata),
            .set_rpend (set_rp_i),
            .bits      (ent_q[i])
        );

        assign tbl_flat[64*i +: 64] = ent_q[i];
        assign mask_v[i] = ent_q[i][F_MASK];
        assign pol_v[i]  = ent_q[i][F_POL];
        assign trig_v[i] = ent_q[i][F_TRIG];
    end

    // Purpose: select the entry and pending bit addressed by the selector.
    always_comb begin
        cur     = '0;
        cur_irr = 1'b0;
        for (int i = 0; i < NPINS; i++)
            if (idx == IDX_W'(i)) begin
                cur     = ent_q[i];
                cur_irr = irr_q[i];
            end
        new_trig = hi ? cur[F_TRIG] : bus_wdata[F_TRIG];
        new_mask = hi ? cur[F_MASK] : bus_wdata[F_MASK];
    end

    // Purpose: selector register, loaded by accepted writes at offset 0x00.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_ok && (bus_addr == OFS_SEL))
            sel_q <= bus_wdata[7:0];
    end

    // Purpose: identifier register, loaded through the window at selector 0x00.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_q <= '0;
        else if (win_wr && (tgt == TGT_ID))
            id_q <= bus_wdata[27:24];
    end

    // Purpose: per-pin pending bits, pin level corrected by entry polarity.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irr_q <= '0;
        else
            irr_q <= pin_in ^ pol_v;
    end

    ioredir_rdmux #(.NPINS(NPINS), .IDX_W(IDX_W), .VER_CODE(VER_CODE)) u_rd (
        .ofs    (bus_addr),
        .sel    (sel_q),
        .tgt    (tgt),
        .idx    (idx),
        .hi     (hi),
        .dev_id (id_q),
        .ents   (ent_q),
        .word   (rd_word)
    );

    // Purpose: register read data on a read strobe and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_word;
    end

    // Purpose: mask-change strobe for low-half writes that flip the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_evt     <= 1'b0;
            mask_evt_pin <= '0;
            mask_evt_val <= 1'b0;
        end else begin
            mask_evt     <= tbl_wr && !hi && (cur[F_MASK] != bus_wdata[F_MASK]);
            mask_evt_pin <= idx;
            mask_evt_val <= bus_wdata[F_MASK];
        end
    end

    // Purpose: service strobe for a rewritten, unmasked, pending level entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_req <= 1'b0;
            svc_pin <= '0;
        end else begin
            svc_req <= tbl_wr && new_trig && !new_mask && cur_irr;
            svc_pin <= idx;
        end
    end

    // R6: a write of an unsupported size changes no entry.
    assert_bad_size_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !size_ok(bus_bytes) && !acc_valid) |=> $stable(tbl_flat));

    // R5: a window write to a non-table selector changes no entry.
    assert_drop_oob_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFS_WIN) && (tgt == TGT_NONE) && !acc_valid)
        |=> $stable(tbl_flat));

    // R3: writes at the arbitration selector leave the identifier alone.
    assert_arb_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFS_WIN) && (tgt == TGT_ARB)) |=> $stable(id_q));

    // R9: the mask strobe reports the mask value now held in the table.
    assert_evt_matches_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt |-> (mask_v[mask_evt_pin] == mask_evt_val));

    // R10: a service strobe names an unmasked level-triggered entry.
    assert_svc_level_unmasked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> (trig_v[svc_pin] && !mask_v[svc_pin]));
endmodule

// File: tb/ioredir_regs_test.sv
// Bench: sweeps every entry and exercises selector decode, sizes,
// remote-pending, mask events and service requests against a model.
module ioredir_regs_test;
    localparam int CLK_P = 10;
    localparam int NP    = 24;
    localparam int IW    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]        bus_bytes = 4'd4;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pin_in = '0;
    logic              acc_valid = 1'b0;
    logic [IW-1:0]     acc_pin = '0;
    logic [64*NP-1:0]  tbl_flat;
    logic              mask_evt, mask_evt_val, svc_req;
    logic [IW-1:0]     mask_evt_pin, svc_pin;

    int n_tests = 0, n_fail = 0;
    logic [63:0] mdl [NP];
    logic ev_mask, ev_val, ev_svc;
    logic [IW-1:0] ev_pin, ev_spin;
    logic [31:0] rv;

    ioredir_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_bytes(bus_bytes), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .acc_valid(acc_valid),
        .acc_pin(acc_pin), .tbl_flat(tbl_flat), .mask_evt(mask_evt),
        .mask_evt_pin(mask_evt_pin), .mask_evt_val(mask_evt_val),
        .svc_req(svc_req), .svc_pin(svc_pin)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] nb);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_bytes = nb; bus_wr = 1'b1;
        @(posedge clk); #1;
        ev_mask = mask_evt; ev_pin = mask_evt_pin; ev_val = mask_evt_val;
        ev_svc = svc_req; ev_spin = svc_pin;
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rwin(input logic [7:0] s, output logic [31:0] d);
        bwrite(8'h00, {24'h0, s}, 4'd4);
        bread(8'h10, d);
    endtask

    // Table half write through the window, model updated per R4/R7.
    task automatic twr(input int p, input bit h, input logic [31:0] d);
        bwrite(8'h00, 32'(8'h10 + 2*p + int'(h)), 4'd4);
        bwrite(8'h10, d, 4'd4);
        if (h) mdl[p][63:32] = d;
        else   mdl[p][31:0]  = d & ~32'h0000_4000;
    endtask

    task automatic chk_table(input string req);
        int bad = 0;
        for (int p = 0; p < NP; p++)
            if (tbl_flat[64*p +: 64] !== mdl[p]) bad++;
        chk(req, 64'(bad), 64'd0);
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) mdl[p] = 64'h0000_0000_0001_0000;
        cycles(3);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state.
        bread(8'h00, rv); chk("R1 selector", 64'(rv), 64'd0);
        chk_table("R1 table");
        for (int p = 0; p < NP; p++) begin
            rwin(8'(8'h10 + 2*p), rv);     chk("R1 low half", 64'(rv), 64'h0001_0000);
            rwin(8'(8'h10 + 2*p + 1), rv); chk("R1 high half", 64'(rv), 64'd0);
        end
        rwin(8'h00, rv); chk("R1 id", 64'(rv), 64'd0);

        // R2: version word, writes ignored.
        rwin(8'h01, rv); chk("R2 version", 64'(rv), 64'h0017_0011);
        bwrite(8'h10, 32'hFFFF_FFFF, 4'd4);
        bread(8'h10, rv); chk("R2 version after write", 64'(rv), 64'h0017_0011);

        // R3: identifier and its alias.
        bwrite(8'h00, 32'h0, 4'd4); bwrite(8'h10, 32'hA5C3_0000, 4'd4);
        bread(8'h10, rv); chk("R3 id", 64'(rv), 64'h0500_0000);
        rwin(8'h02, rv); chk("R3 arb alias", 64'(rv), 64'h0500_0000);
        bwrite(8'h10, 32'hF000_0000, 4'd4);
        rwin(8'h00, rv); chk("R3 arb write ignored", 64'(rv), 64'h0500_0000);

        // R4/R7/R9/R12: sweep every entry.
        for (int p = 0; p < NP; p++) begin
            logic [7:0]  b = 8'(p);
            logic [31:0] lo = ({b, b, b, b} ^ 32'h3C00_C0A5) & ~32'h0001_2000;
            logic [31:0] hv = {b, ~b, b ^ 8'h5A, 8'h77};
            twr(p, 1'b0, lo);
            chk("R9 unmask event", {ev_mask, ev_val, 3'b0, ev_pin}, {1'b1, 1'b0, 3'b0, 5'(p)});
            chk("R10 no svc while idle", 64'(ev_svc), 64'd0);
            twr(p, 1'b1, hv);
            rwin(8'(8'h10 + 2*p), rv);     chk("R4 R7 low half", 64'(rv), 64'(lo & ~32'h4000));
            rwin(8'(8'h10 + 2*p + 1), rv); chk("R4 high half", 64'(rv), 64'(hv));
            chk("R12 flat slice", tbl_flat[64*p +: 64], mdl[p]);
        end

        // R5: out-of-range indices and reserved selectors.
        bwrite(8'h00, 32'h40, 4'd4); bwrite(8'h10, 32'hFFFF_FFFF, 4'd4);
        chk_table("R5 oob write dropped");
        bread(8'h10, rv); chk("R5 oob read", 64'(rv), 64'd0);
        rwin(8'h0F, rv); chk("R5 reserved read", 64'(rv), 64'd0);
        bwrite(8'h10, 32'hFFFF_FFFF, 4'd4);
        chk_table("R5 reserved write");
        rwin(8'hFF, rv); chk("R5 top selector read", 64'(rv), 64'd0);

        // R6: access sizes.
        bwrite(8'h00, 32'h16, 4'd4);
        bwrite(8'h10, 32'h1234_5678, 4'd2);
        chk_table("R6 2-byte write ignored");
        bwrite(8'h00, 32'h20, 4'd1);
        bread(8'h00, rv); chk("R6 1-byte selector write ignored", 64'(rv), 64'h16);
        bwrite(8'h10, mdl[3][31:0] ^ 32'h55, 4'd8);
        mdl[3][31:0] = mdl[3][31:0] ^ 32'h55;
        chk_table("R6 8-byte write taken");

        // R8/R7: remote-pending.
        @(negedge clk); acc_valid = 1'b1; acc_pin = 5'd4;
        @(posedge clk); #1; acc_valid = 1'b0;
        mdl[4][14] = 1'b1;
        rwin(8'h18, rv); chk("R8 remote set on level", 64'(rv[14]), 64'd1);
        twr(4, 1'b1, 32'hC300_0000);
        chk("R8 high write keeps remote", tbl_flat[64*4 + 14], 1'b1);
        twr(4, 1'b0, mdl[4][31:0] | 32'h4000);
        chk("R7 low write clears remote", tbl_flat[64*4 + 14], 1'b0);
        twr(5, 1'b0, mdl[5][31:0] & ~32'h8000);
        @(negedge clk); acc_valid = 1'b1; acc_pin = 5'd5;
        @(posedge clk); #1; acc_valid = 1'b0;
        chk("R8 edge entry no remote", tbl_flat[64*5 + 14], 1'b0);
        chk_table("R8 table");

        // R9: mask events.
        twr(7, 1'b0, mdl[7][31:0]);
        chk("R9 same mask no event", 64'(ev_mask), 64'd0);
        twr(7, 1'b0, mdl[7][31:0] | 32'h1_0000);
        chk("R9 mask event", {ev_mask, ev_val, 3'b0, ev_pin}, {1'b1, 1'b1, 3'b0, 5'd7});
        twr(7, 1'b0, mdl[7][31:0]);
        chk("R9 repeat mask no event", 64'(ev_mask), 64'd0);

        // R10: service requests.
        @(negedge clk); pin_in[6] = 1'b1; pin_in[7] = 1'b1; pin_in[5] = 1'b1;
        cycles(2);
        twr(6, 1'b1, mdl[6][63:32]);
        chk("R10 svc level pending", {ev_svc, 3'b0, ev_spin}, {1'b1, 3'b0, 5'd6});
        twr(7, 1'b1, mdl[7][63:32]);
        chk("R10 masked no svc", 64'(ev_svc), 64'd0);
        twr(5, 1'b1, mdl[5][63:32]);
        chk("R10 edge no svc", 64'(ev_svc), 64'd0);
        twr(8, 1'b0, mdl[8][31:0] | 32'h2000);
        chk("R10 old pending used", 64'(ev_svc), 64'd0);
        cycles(2);
        twr(8, 1'b1, mdl[8][63:32]);
        chk("R10 polarity pending", {ev_svc, 3'b0, ev_spin}, {1'b1, 3'b0, 5'd8});

        // R11: other offsets and selector width.
        bread(8'h20, rv); chk("R11 other offset read", 64'(rv), 64'd0);
        bwrite(8'h20, 32'hDEAD_BEEF, 4'd4);
        chk_table("R11 other offset write");
        bwrite(8'h00, 32'h1AB, 4'd4);
        bread(8'h00, rv); chk("R11 selector 8 bits", 64'(rv), 64'hAB);
        chk_table("R12 final table");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule